// File: doc/BRIEF.md
# Store-Drain Decode Stall Tracker

This block decides, cycle by cycle, whether the decode stage of a small in-order pipeline may take the bundle offered by fetch. Decode keeps a speculative count of the stores it expects its issued bundles to send. Execute keeps a single shared count of stores that have finished. Decode issues only while the two counts match. While they differ it holds the bundle in place and tries again on the next cycle.

Execute raises up to three completion events per cycle: an undo store for a squashed autoincrement worth two, an autoincrement retire worth one, and a final store worth one. They are summed into the shared count in the cycle they occur. Decode's comparison already sees that cycle's sum. The shared count is only ever compared for equality, so it is published in Gray code.

A redirect reloads the speculative count from the value carried with the redirect. Bundles from a stale generation are discarded without looking at the counts. The block also forms the one-hot byte-lane mask that goes with a store, from the byte offset of its address within a memory line.

Top module: `store_drain_gate`

## Requirements
- R1: While `rst_n` is low at a rising edge, both counts are cleared, so `spec_count` and `done_gray` read 0 after that edge.
- R2: At each edge the done count grows by 2·`ex_undo` + `ex_autoinc_retire` + `ex_final_store`, so it can grow by as much as 4. `done_gray` then holds the new count in Gray code, which is count XOR (count >> 1).
- R3: With no redirect, `issue` and `fetch_pop` are high in the same cycle when `fetch_valid` and all three readies are high, `fetch_gen` equals `cur_gen`, and `spec_count` equals the done count including this cycle's execute increments.
- R4: If `fetch_valid` or any of `memcmd_ready`, `indir_ready` or `exec_ready` is low, then `issue`, `fetch_pop` and `stall` are all low, and `spec_count` does not change at the next edge.
- R5: A bundle that could be accepted but has `fetch_gen` different from `cur_gen` is popped without being issued (`fetch_pop`=1, `issue`=0, `stall`=0), whatever the counts are, and `spec_count` does not change.
- R6: A bundle that could be accepted, of the current generation, while the counts differ raises `stall` with `fetch_pop` and `issue` low, and `spec_count` keeps its value.
- R7: Execute increments made in a cycle count in that same cycle's comparison. A bundle that was waiting therefore issues in the cycle its last store completes.
- R8: On an issue, `spec_count` grows by `fetch_stores` at the next edge.
- R9: While `redirect_valid` is high, `spec_count` is loaded with `redirect_count` at the next edge and `issue`, `fetch_pop` and `stall` are low. Execute increments still reach the done count.
- R10: `st_mask` has exactly one bit set, at bit position `st_offset`.
- R11: Both counts wrap modulo 2^CNT_W (256 by default), and equality is still detected across the wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| redirect_valid | input | 1 | Restart: reload the speculative count |
| redirect_count | input | CNT_W | Store count carried by the restart |
| cur_gen | input | GEN_W | Current pipeline generation |
| fetch_valid | input | 1 | Fetch offers a bundle |
| fetch_gen | input | GEN_W | Generation tag of the offered bundle |
| fetch_stores | input | ST_W | Stores the offered bundle will send |
| memcmd_ready | input | 1 | Memory-command output can accept |
| indir_ready | input | 1 | Indirect-stage output can accept |
| exec_ready | input | 1 | Execute-stage output can accept |
| ex_undo | input | 1 | Execute sent an undo store (+2) |
| ex_autoinc_retire | input | 1 | Retire of an autoincrement instruction (+1) |
| ex_final_store | input | 1 | Execute sent a final store (+1) |
| st_offset | input | OFF_W | Byte offset of the store within a line |
| st_mask | output | LINE_BYTES | One-hot byte-lane mask |
| fetch_pop | output | 1 | Bundle consumed (issued or dropped) |
| issue | output | 1 | Bundle issued downstream |
| stall | output | 1 | Bundle held because stores are outstanding |
| spec_count | output | CNT_W | Speculative stores-sent count |
| done_gray | output | CNT_W | Gray-coded stores-done count |

## Verification
The bench goes after the cycle in which the last outstanding store completes. A design that compares against the registered done count would stall one cycle too long there, and the issue check shows it. The summed cycle with all three execute events tests the +4 step: a design that drops an event or weighs the undo as one falls behind on `done_gray`. Stale bundles are offered while the counts differ, so a design that checks the counts before the generation stalls where it should pop. Long runs that cross 255 catch a comparison that fails at the wrap. Redirects with back-pressure on the same cycle catch a design that issues or keeps the old count during a restart.

// File: rtl/sdg_pkg.sv
// Shared definitions for the store-drain decode stall tracker.
// Assumes: execute reports at most one event of each kind per cycle.
package sdg_pkg;
    // Width of the summed per-cycle execute increment (max 2+1+1 = 4).
    localparam int EXEC_INC_W = 3;

    // Outcome of the decode decision for one cycle.
    typedef enum logic [2:0] {
        DEC_IDLE,     // nothing offered or no room downstream
        DEC_BLOCKED,  // redirect in progress
        DEC_DROP,     // stale generation, discard
        DEC_STALL,    // stores outstanding, hold
        DEC_ISSUE     // send bundle downstream
    } dec_e;
endpackage

// File: rtl/sdg_done_counter.sv
// Shared stores-done counter.
// Sums the execute events of the cycle, keeps the count in binary and
// registers its Gray form. It also presents the Gray form of the updated
// count so that decode sees this cycle's increments in the same cycle.
// Assumes: all events are single-cycle strobes; the count wraps mod 2^CNT_W.
module sdg_done_counter
    import sdg_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_undo,
    input  logic             ev_autoinc,
    input  logic             ev_final,
    output logic [CNT_W-1:0] next_gray,
    output logic [CNT_W-1:0] gray_q
);
    logic [EXEC_INC_W-1:0] inc;
    logic [CNT_W-1:0]      bin_q;
    logic [CNT_W-1:0]      bin_next;

    // Sum this cycle's completion events into one increment.
    always_comb begin
        inc = EXEC_INC_W'({ev_undo, 1'b0}) + EXEC_INC_W'(ev_autoinc)
            + EXEC_INC_W'(ev_final);
        bin_next  = bin_q + CNT_W'(inc);
        next_gray = bin_next ^ (bin_next >> 1);
    end

    // Register the binary count and its Gray form.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bin_q  <= '0;
            gray_q <= '0;
        end else begin
            bin_q  <= bin_next;
            gray_q <= next_gray;
        end
    end
endmodule

// File: rtl/sdg_spec_counter.sv
// Decode's speculative stores-sent counter.
// A reload from a redirect takes priority over an advance on issue.
// Assumes: the reload value is already in binary.
module sdg_spec_counter #(
    parameter int CNT_W = 8,
    parameter int ST_W  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reload,
    input  logic [CNT_W-1:0] reload_val,
    input  logic             advance,
    input  logic [ST_W-1:0]  adv_amount,
    output logic [CNT_W-1:0] count_q,
    output logic [CNT_W-1:0] count_gray
);
    // Load, advance or hold the speculative count.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count_q <= '0;
        else if (reload)
            count_q <= reload_val;
        else if (advance)
            count_q <= count_q + CNT_W'(adv_amount);
    end

    // Gray view of the count for the equality test.
    always_comb count_gray = count_q ^ (count_q >> 1);
endmodule

// File: rtl/sdg_issue_ctrl.sv
// Decode accept decision.
// Precedence: redirect, then handshake, then generation, then store drain.
// Assumes: counts_equal already includes this cycle's execute increments.
module sdg_issue_ctrl
    import sdg_pkg::*;
#(
    parameter int GEN_W = 2
) (
    input  logic             redirect,
    input  logic             fetch_valid,
    input  logic [GEN_W-1:0] fetch_gen,
    input  logic [GEN_W-1:0] cur_gen,
    input  logic             memcmd_ready,
    input  logic             indir_ready,
    input  logic             exec_ready,
    input  logic             counts_equal,
    output logic             issue,
    output logic             pop,
    output logic             stall
);
    dec_e dec;

    // Classify the cycle.
    always_comb begin
        if (redirect)
            dec = DEC_BLOCKED;
        else if (!(fetch_valid && memcmd_ready && indir_ready && exec_ready))
            dec = DEC_IDLE;
        else if (fetch_gen != cur_gen)
            dec = DEC_DROP;
        else if (!counts_equal)
            dec = DEC_STALL;
        else
            dec = DEC_ISSUE;
    end

    // Decode the classification into strobes.
    always_comb begin
        issue = (dec == DEC_ISSUE);
        pop   = (dec == DEC_ISSUE) || (dec == DEC_DROP);
        stall = (dec == DEC_STALL);
    end
endmodule

// File: rtl/sdg_byte_mask.sv
// One-hot byte-lane mask for a store, selected by the offset within a line.
// Assumes: LINE_BYTES is a power of two.
module sdg_byte_mask #(
    parameter int LINE_BYTES = 8,
    localparam int OFF_W     = $clog2(LINE_BYTES)
) (
    input  logic [OFF_W-1:0]      offset,
    output logic [LINE_BYTES-1:0] mask
);
    // One comparator per lane.
    for (genvar g = 0; g < LINE_BYTES; g++) begin : g_lane
        assign mask[g] = (offset == OFF_W'(g));
    end
endmodule

// File: rtl/store_drain_gate.sv
// Store-drain decode stall tracker (top).
// Holds decode while its speculative stores-sent count differs from the
// shared stores-done count, which execute advances in the event cycle.
// Assumes: synchronous active-low reset; outputs issue/pop/stall are
// combinational from inputs and registered counts.
module store_drain_gate #(
    parameter int CNT_W      = 8,
    parameter int GEN_W      = 2,
    parameter int ST_W       = 2,
    parameter int LINE_BYTES = 8,
    localparam int OFF_W     = $clog2(LINE_BYTES)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  redirect_valid,
    input  logic [CNT_W-1:0]      redirect_count,
    input  logic [GEN_W-1:0]      cur_gen,
    input  logic                  fetch_valid,
    input  logic [GEN_W-1:0]      fetch_gen,
    input  logic [ST_W-1:0]       fetch_stores,
    input  logic                  memcmd_ready,
    input  logic                  indir_ready,
    input  logic                  exec_ready,
    input  logic                  ex_undo,
    input  logic                  ex_autoinc_retire,
    input  logic                  ex_final_store,
    input  logic [OFF_W-1:0]      st_offset,
    output logic [LINE_BYTES-1:0] st_mask,
    output logic                  fetch_pop,
    output logic                  issue,
    output logic                  stall,
    output logic [CNT_W-1:0]      spec_count,
    output logic [CNT_W-1:0]      done_gray
);
    logic [CNT_W-1:0] done_next_gray;
    logic [CNT_W-1:0] spec_gray;
    logic             counts_equal;

    sdg_done_counter #(.CNT_W(CNT_W)) u_done (
        .clk        (clk),
        .rst_n      (rst_n),
        .ev_undo    (ex_undo),
        .ev_autoinc (ex_autoinc_retire),
        .ev_final   (ex_final_store),
        .next_gray  (done_next_gray),
        .gray_q     (done_gray)
    );

    sdg_spec_counter #(.CNT_W(CNT_W), .ST_W(ST_W)) u_spec (
        .clk        (clk),
        .rst_n      (rst_n),
        .reload     (redirect_valid),
        .reload_val (redirect_count),
        .advance    (issue),
        .adv_amount (fetch_stores),
        .count_q    (spec_count),
        .count_gray (spec_gray)
    );

    // Equality only, taken on the Gray forms.
    always_comb counts_equal = (spec_gray == done_next_gray);

    sdg_issue_ctrl #(.GEN_W(GEN_W)) u_ctrl (
        .redirect     (redirect_valid),
        .fetch_valid  (fetch_valid),
        .fetch_gen    (fetch_gen),
        .cur_gen      (cur_gen),
        .memcmd_ready (memcmd_ready),
        .indir_ready  (indir_ready),
        .exec_ready   (exec_ready),
        .counts_equal (counts_equal),
        .issue        (issue),
        .pop          (fetch_pop),
        .stall        (stall)
    );

    sdg_byte_mask #(.LINE_BYTES(LINE_BYTES)) u_mask (
        .offset (st_offset),
        .mask   (st_mask)
    );
endmodule

// File: rtl/store_drain_gate_chk.sv
// Property checker for store_drain_gate, attached by bind.
// Assumes: reset is held low for at least the first clock edge.
module store_drain_gate_chk #(
    parameter int CNT_W      = 8,
    parameter int ST_W       = 2,
    parameter int LINE_BYTES = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  redirect_valid,
    input logic [CNT_W-1:0]      redirect_count,
    input logic                  fetch_valid,
    input logic [ST_W-1:0]       fetch_stores,
    input logic                  memcmd_ready,
    input logic                  indir_ready,
    input logic                  exec_ready,
    input logic                  ex_undo,
    input logic                  ex_autoinc_retire,
    input logic                  ex_final_store,
    input logic [LINE_BYTES-1:0] st_mask,
    input logic                  fetch_pop,
    input logic                  issue,
    input logic                  stall,
    input logic [CNT_W-1:0]      spec_count,
    input logic [CNT_W-1:0]      done_gray
);
    AST_RESET_CLEAR: assert property (@(posedge clk) $past(!rst_n) |-> (spec_count == '0 && done_gray == '0)); // R1
    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!ex_undo && !ex_autoinc_retire && !ex_final_store) |=> $stable(done_gray)); // R2
    AST_ISSUE_POPS: assert property (@(posedge clk) disable iff (!rst_n) issue |-> fetch_pop); // R3
    AST_NO_ACCEPT_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !(fetch_valid && memcmd_ready && indir_ready && exec_ready) |-> (!fetch_pop && !stall)); // R4
    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({issue, stall, fetch_pop && !issue})); // R5
    AST_STALL_KEEPS: assert property (@(posedge clk) disable iff (!rst_n) stall |=> $stable(spec_count)); // R6
    AST_ISSUE_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n) issue |=> spec_count == $past(spec_count) + CNT_W'($past(fetch_stores))); // R8
    AST_REDIRECT_LOAD: assert property (@(posedge clk) disable iff (!rst_n) redirect_valid |=> spec_count == $past(redirect_count)); // R9
    AST_REDIRECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n) redirect_valid |-> (!fetch_pop && !stall)); // R9
    AST_MASK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $countones(st_mask) == 1); // R10
endmodule

bind store_drain_gate store_drain_gate_chk #(
    .CNT_W(CNT_W), .ST_W(ST_W), .LINE_BYTES(LINE_BYTES)
) u_chk (.*);

// File: tb/store_drain_gate_tb.sv
// Cycle-by-cycle behavioural model of the tracker, compared every clock.
module store_drain_gate_tb;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W = 8, GEN_W = 2, ST_W = 2, LINE_BYTES = 8, OFF_W = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic redirect_valid = 1'b0;
    logic [CNT_W-1:0] redirect_count = '0;
    logic [GEN_W-1:0] cur_gen = '0, fetch_gen = '0;
    logic fetch_valid = 1'b0;
    logic [ST_W-1:0] fetch_stores = '0;
    logic memcmd_ready = 1'b1, indir_ready = 1'b1, exec_ready = 1'b1;
    logic ex_undo = 1'b0, ex_autoinc_retire = 1'b0, ex_final_store = 1'b0;
    logic [OFF_W-1:0] st_offset = '0;
    logic [LINE_BYTES-1:0] st_mask;
    logic fetch_pop, issue, stall;
    logic [CNT_W-1:0] spec_count, done_gray;

    int n_checks = 0, n_fail = 0;
    int m_spec = 0, m_done = 0;
    string cur_req = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    store_drain_gate #(.CNT_W(CNT_W), .GEN_W(GEN_W), .ST_W(ST_W), .LINE_BYTES(LINE_BYTES)) u_dut (.*);

    task automatic chk(string req, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s [%s] %s: actual %0d expected %0d", req, cur_req, what, act, exp);
        end
    endtask

    // Compare just before the edge, then advance the model across it.
    task automatic tick();
        int inc, done_now, go, match, e_issue, e_pop, e_stall;
        @(negedge clk);
        inc = 2*int'(ex_undo) + int'(ex_autoinc_retire) + int'(ex_final_store);
        done_now = (m_done + inc) % 256;
        go = (!redirect_valid && fetch_valid && memcmd_ready && indir_ready && exec_ready) ? 1 : 0;
        match = (fetch_gen == cur_gen) ? 1 : 0;
        e_issue = (go && match && m_spec == done_now) ? 1 : 0;
        e_stall = (go && match && m_spec != done_now) ? 1 : 0;
        e_pop = (go && (!match || m_spec == done_now)) ? 1 : 0;
        if (rst_n) begin
            chk("R3", "issue", int'(issue), e_issue);
            chk("R6", "stall", int'(stall), e_stall);
            chk("R5", "fetch_pop", int'(fetch_pop), e_pop);
            chk("R8", "spec_count", int'(spec_count), m_spec);
            chk("R2", "done_gray", int'(done_gray), m_done ^ (m_done >> 1));
            chk("R10", "st_mask", int'(st_mask), 1 << st_offset);
        end
        @(posedge clk);
        if (!rst_n) begin
            m_spec = 0; m_done = 0;
        end else begin
            m_done = done_now;
            if (redirect_valid) m_spec = int'(redirect_count);
            else if (e_issue) m_spec = (m_spec + int'(fetch_stores)) % 256;
        end
        #1;
    endtask

    task automatic quiet();
        redirect_valid = 0; fetch_valid = 0; ex_undo = 0;
        ex_autoinc_retire = 0; ex_final_store = 0;
        memcmd_ready = 1; indir_ready = 1; exec_ready = 1;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        // R1: reset clears both counts
        repeat (3) tick();
        rst_n = 1;
        @(negedge clk);
        chk("R1", "spec_count", int'(spec_count), 0);
        chk("R1", "done_gray", int'(done_gray), 0);
        @(posedge clk); #1;

        // R3: equal counts, current generation: issue, 2 stores expected
        cur_req = "R3";
        fetch_valid = 1; fetch_stores = 2; tick();
        // R6: now spec=2, done=0: stall
        cur_req = "R6"; tick();
        // R7: one store completes, still stalled; next one issues same cycle
        cur_req = "R7";
        ex_final_store = 1; fetch_stores = 0; tick();
        tick();
        ex_final_store = 0;
        // R4: each ready low in turn
        cur_req = "R4";
        memcmd_ready = 0; tick(); memcmd_ready = 1;
        indir_ready = 0; tick(); indir_ready = 1;
        exec_ready = 0; tick(); exec_ready = 1;
        fetch_valid = 0; tick(); fetch_valid = 1;
        // R5: stale bundle while counts differ is dropped
        cur_req = "R5";
        fetch_stores = 3; tick();
        fetch_gen = 2'd1; tick(); tick();
        // R2: all three events at once (+4), with undo alone (+2)
        cur_req = "R2";
        fetch_valid = 0; ex_undo = 1; ex_autoinc_retire = 1; ex_final_store = 1;
        tick();
        ex_autoinc_retire = 0; ex_final_store = 0; tick(); quiet();
        // R9: redirect with back-pressure off, execute still counting
        cur_req = "R9";
        cur_gen = 2'd1; fetch_valid = 1; redirect_valid = 1;
        redirect_count = 8'd200; ex_final_store = 1; tick();
        quiet(); tick();
        // R10: sweep byte offsets
        cur_req = "R10";
        for (int k = 0; k < LINE_BYTES; k++) begin
            st_offset = OFF_W'(k); tick();
        end
        // R11: long mixed traffic crossing the wrap many times
        cur_req = "R11";
        for (int c = 0; c < 3000; c++) begin
            int gap;
            gap = (m_spec - m_done + 256) % 256;
            fetch_valid = ($urandom % 4) != 0;
            fetch_gen = (($urandom % 8) == 0) ? cur_gen + 2'd1 : cur_gen;
            fetch_stores = ST_W'($urandom % 4);
            memcmd_ready = ($urandom % 8) != 0;
            indir_ready = ($urandom % 8) != 0;
            exec_ready = ($urandom % 8) != 0;
            ex_undo = (gap >= 2) && ($urandom % 2);
            ex_autoinc_retire = (gap >= 2 * int'(ex_undo) + 1) && ($urandom % 2);
            ex_final_store = (gap >= 2 * int'(ex_undo) + int'(ex_autoinc_retire) + 1) && ($urandom % 2);
            redirect_valid = ($urandom % 64) == 0;
            redirect_count = (($urandom % 2) != 0) ? CNT_W'(m_done) : CNT_W'($urandom);
            st_offset = OFF_W'($urandom);
            tick();
        end
        quiet(); tick();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule